// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Tracker

This block sits beside a DDR3-style memory interface and watches, on every rising clock edge, the clock-enable level and the command on the chip-select and strobe lines. From the clock-enable level at the previous edge and at the present edge, the decoded command, and a status code that describes what the device was doing just before the edge, it works out which power mode the device is in. The four modes are normal operation, active power-down, precharge power-down and self refresh.

Each entry into a low-power mode and each return to normal operation produces a one-cycle pulse. Any combination of mode, clock-enable pair and command that the rules do not allow raises a sticky error flag and leaves the tracked mode as it was. A clock-enable level that changes again before it has been held for the minimum number of registered edges also raises the error flag. The minimum hold count is the parameter `TCKE_MIN`, which defaults to 3.

Top module: `cke_power_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `pwr_mode` reads 0 (normal), `enter_pulse` and `exit_pulse` are low and `err_flag` is clear. The register that holds the previous clock-enable level resets to high.
- R2: The command is decoded from {cs_n, ras_n, cas_n, we_n}. cs_n high means deselect, whatever the other three lines are. 0111 means no-operation. 0001 means refresh. Every other pattern is a different command.
- R3: When clock-enable goes from high to low with deselect or no-operation while `dev_state` is 1 (bank active), 2 (reading) or 3 (writing), the mode becomes 1 (active power-down).
- R4: When clock-enable goes from high to low with deselect or no-operation while `dev_state` is 0 (all banks idle), 4 (precharging) or 5 (refreshing), the mode becomes 2 (precharge power-down).
- R5: When clock-enable goes from high to low with a refresh command while `dev_state` is 0, the mode becomes 3 (self refresh).
- R6: While the mode is 1, 2 or 3 and clock-enable is low at both edges, the mode stays the same for every command, and no error is raised.
- R7: When clock-enable goes from low to high with deselect or no-operation in any low-power mode, the mode returns to 0.
- R8: While the mode is 0 and clock-enable is high at both edges, the mode stays 0 for every command, and no error is raised.
- R9: Every other combination raises `err_flag` and leaves the mode unchanged. This includes a high-to-low edge with any other command, a refresh while the device is not idle, a `dev_state` of 6 or 7, and a low-to-high edge with any other command.
- R10: After a clock-enable change, the new level must be registered at `TCKE_MIN` consecutive edges, counting the edge of the change. A change at an earlier edge raises `err_flag`, and the mode is still updated as R3 to R7 give. A change at exactly the `TCKE_MIN`-th following edge is legal.
- R11: Once `err_flag` is set, it stays set until reset.
- R12: All outputs are registered and update at the edge that samples the inputs. `enter_pulse` is high for one cycle when the mode leaves 0. `exit_pulse` is high for one cycle when the mode returns to 0. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dev_state | input | 3 | Device activity just before the edge (codes in R3 to R5) |
| pwr_mode | output | 2 | Tracked power mode (0 normal, 1 active PD, 2 precharge PD, 3 self refresh) |
| enter_pulse | output | 1 | One-cycle pulse on entry to a low-power mode |
| exit_pulse | output | 1 | One-cycle pulse on return to normal |
| err_flag | output | 1 | Sticky illegal-transition or hold-time error |

## Verification
Some rules are checked by the assertions on every cycle:
- the error flag never clears once set;
- the two pulses never occur together, and an entry pulse appears only with a mode that has just left normal;
- both-low edges keep the mode, and both-high edges keep normal mode;
- a quiet low-to-high edge always exits;
- an early clock-enable change always sets the error.

Other rules can only be shown by the bench's scenarios:
- which low-power mode each device state leads to;
- that chip select alone marks a deselect;
- that each illegal combination leaves the mode untouched;
- that a change at exactly the minimum hold count stays legal.

// File: rtl/cke_pm_pkg.sv
package cke_pm_pkg;

   localparam int MODE_W = 2;
   localparam int ACT_W  = 3;

   typedef enum logic [MODE_W-1:0] {
      PM_NORMAL   = 2'd0,
      PM_ACT_PD   = 2'd1,
      PM_PRE_PD   = 2'd2,
      PM_SELF_REF = 2'd3
   } pm_mode_e;

   typedef enum logic [1:0] {
      CMD_DESEL   = 2'd0,
      CMD_NOP     = 2'd1,
      CMD_REFRESH = 2'd2,
      CMD_OTHER   = 2'd3
   } cmd_e;

   // device activity codes
   localparam logic [ACT_W-1:0] ACT_IDLE    = 3'd0;
   localparam logic [ACT_W-1:0] ACT_BANK    = 3'd1;
   localparam logic [ACT_W-1:0] ACT_READ    = 3'd2;
   localparam logic [ACT_W-1:0] ACT_WRITE   = 3'd3;
   localparam logic [ACT_W-1:0] ACT_PRECHG  = 3'd4;
   localparam logic [ACT_W-1:0] ACT_REFRESH = 3'd5;

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
   import cke_pm_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b001:  cmd = CMD_REFRESH;
            default: cmd = CMD_OTHER;
         endcase
      end
   end

endmodule

// File: rtl/cke_hold_monitor.sv
module cke_hold_monitor #(
   parameter int TCKE_MIN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic cke_prev,
   output logic hold_viol
);

   localparam int CNT_W = $clog2(TCKE_MIN + 1);

   logic changed;
   assign changed = cke ^ cke_prev;

   generate
      if (TCKE_MIN < 1) begin : g_bad_param
         $error("cke_hold_monitor: TCKE_MIN must be at least 1");
      end

      if (TCKE_MIN <= 1) begin : g_no_hold
         // every level is held for one edge by definition
         assign hold_viol = 1'b0;
      end else begin : g_hold_cnt
         localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TCKE_MIN);
         logic [CNT_W-1:0] held_cnt;

         assign hold_viol = changed && (held_cnt < CNT_FULL);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held_cnt <= CNT_FULL;
            end else if (changed) begin
               held_cnt <= CNT_W'(1);
            end else if (held_cnt != CNT_FULL) begin
               held_cnt <= held_cnt + CNT_W'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cke_mode_fsm.sv
module cke_mode_fsm
   import cke_pm_pkg::*;
(
   input  logic             cke,
   input  logic             cke_prev,
   input  cmd_e             cmd,
   input  logic [ACT_W-1:0] dev_state,
   input  pm_mode_e         mode,
   output pm_mode_e         mode_nxt,
   output logic             illegal
);

   logic quiet;
   logic low_power;

   assign quiet     = (cmd == CMD_DESEL) || (cmd == CMD_NOP);
   assign low_power = (mode != PM_NORMAL);

   always_comb begin
      mode_nxt = mode;
      illegal  = 1'b0;
      case ({cke_prev, cke})
         2'b11: begin
            if (low_power) illegal = 1'b1;
         end
         2'b10: begin
            if (low_power) begin
               illegal = 1'b1;
            end else if (quiet) begin
               case (dev_state)
                  ACT_BANK, ACT_READ, ACT_WRITE:      mode_nxt = PM_ACT_PD;
                  ACT_IDLE, ACT_PRECHG, ACT_REFRESH:  mode_nxt = PM_PRE_PD;
                  default:                            illegal  = 1'b1;
               endcase
            end else if (cmd == CMD_REFRESH && dev_state == ACT_IDLE) begin
               mode_nxt = PM_SELF_REF;
            end else begin
               illegal = 1'b1;
            end
         end
         2'b00: begin
            if (!low_power) illegal = 1'b1;
         end
         default: begin
            if (low_power && quiet) mode_nxt = PM_NORMAL;
            else                    illegal  = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
   import cke_pm_pkg::*;
#(
   parameter int TCKE_MIN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [ACT_W-1:0] dev_state,
   output logic [MODE_W-1:0] pwr_mode,
   output logic             enter_pulse,
   output logic             exit_pulse,
   output logic             err_flag
);

   cmd_e     cmd;
   pm_mode_e mode_q;
   pm_mode_e mode_nxt;
   logic     cke_q;
   logic     illegal;
   logic     hold_viol;
   logic     enter_q, exit_q, err_q;

   cke_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   cke_mode_fsm u_fsm (
      .cke       (cke),
      .cke_prev  (cke_q),
      .cmd       (cmd),
      .dev_state (dev_state),
      .mode      (mode_q),
      .mode_nxt  (mode_nxt),
      .illegal   (illegal)
   );

   cke_hold_monitor #(.TCKE_MIN(TCKE_MIN)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke),
      .cke_prev  (cke_q),
      .hold_viol (hold_viol)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q   <= 1'b1;
         mode_q  <= PM_NORMAL;
         enter_q <= 1'b0;
         exit_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         cke_q   <= cke;
         mode_q  <= mode_nxt;
         enter_q <= (mode_q == PM_NORMAL) && (mode_nxt != PM_NORMAL);
         exit_q  <= (mode_q != PM_NORMAL) && (mode_nxt == PM_NORMAL);
         err_q   <= err_q | illegal | hold_viol;
      end
   end

   assign pwr_mode    = mode_q;
   assign enter_pulse = enter_q;
   assign exit_pulse  = exit_q;
   assign err_flag    = err_q;

endmodule

// File: rtl/cke_power_tracker_chk.sv
module cke_power_tracker_chk #(
   parameter int TCKE_MIN = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic       cs_n,
   input logic       ras_n,
   input logic       cas_n,
   input logic       we_n,
   input logic [1:0] pwr_mode,
   input logic       enter_pulse,
   input logic       exit_pulse,
   input logic       err_flag
);

   logic     cke_seen;
   int       since_chg;
   logic     quiet_cmd;

   assign quiet_cmd = cs_n || ({ras_n, cas_n, we_n} == 3'b111);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_seen  <= 1'b1;
         since_chg <= TCKE_MIN;
      end else begin
         cke_seen  <= cke;
         if (cke != cke_seen)       since_chg <= 1;
         else if (since_chg < TCKE_MIN) since_chg <= since_chg + 1;
      end
   end

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   a_r12_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(enter_pulse && exit_pulse));

   a_r12_enter_leaves_normal: assert property (@(posedge clk) disable iff (!rst_n)
      enter_pulse |-> (pwr_mode != 2'd0 && $past(pwr_mode) == 2'd0));

   a_r6_low_low_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode != 2'd0 && !cke && !cke_seen) |=> $stable(pwr_mode));

   a_r7_quiet_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode != 2'd0 && cke && !cke_seen && quiet_cmd) |=> (pwr_mode == 2'd0 && exit_pulse));

   a_r8_high_high_normal: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode == 2'd0 && cke && cke_seen) |=> (pwr_mode == 2'd0));

   a_r10_early_change: assert property (@(posedge clk) disable iff (!rst_n)
      (cke != cke_seen && since_chg < TCKE_MIN) |=> err_flag);

endmodule

bind cke_power_tracker cke_power_tracker_chk #(.TCKE_MIN(TCKE_MIN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cke         (cke),
   .cs_n        (cs_n),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .we_n        (we_n),
   .pwr_mode    (pwr_mode),
   .enter_pulse (enter_pulse),
   .exit_pulse  (exit_pulse),
   .err_flag    (err_flag)
);

// File: tb/cke_power_tracker_tb.sv
module cke_power_tracker_tb;

   localparam logic [3:0] C_DES  = 4'b1111;
   localparam logic [3:0] C_DESR = 4'b1001; // deselect with refresh pattern on strobes
   localparam logic [3:0] C_NOP  = 4'b0111;
   localparam logic [3:0] C_REF  = 4'b0001;
   localparam logic [3:0] C_ACT  = 4'b0011;
   localparam logic [3:0] C_RD   = 4'b0101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic [3:0] cmdv = C_DES;
   logic [2:0] dev_state = 3'd0;
   logic [1:0] pwr_mode;
   logic       enter_pulse, exit_pulse, err_flag;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   cke_power_tracker #(.TCKE_MIN(3)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cke         (cke),
      .cs_n        (cmdv[3]),
      .ras_n       (cmdv[2]),
      .cas_n       (cmdv[1]),
      .we_n        (cmdv[0]),
      .dev_state   (dev_state),
      .pwr_mode    (pwr_mode),
      .enter_pulse (enter_pulse),
      .exit_pulse  (exit_pulse),
      .err_flag    (err_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input logic k, input logic [3:0] c, input logic [2:0] st);
      cke = k; cmdv = c; dev_state = st;
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(1'b1, C_DES, 3'd0);
      step(1'b1, C_DES, 3'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 mode", pwr_mode, 0);
      check("R1 enter", enter_pulse, 0);
      check("R1 exit", exit_pulse, 0);
      check("R1 err", err_flag, 0);
   endtask

   task automatic t_normal();
      do_reset();
      step(1'b1, C_REF, 3'd0);
      step(1'b1, C_ACT, 3'd1);
      step(1'b1, C_RD, 3'd2);
      step(1'b1, C_NOP, 3'd7);
      check("R8 mode stays normal", pwr_mode, 0);
      check("R8 no error", err_flag, 0);
   endtask

   // enter a low-power mode, sit in it, then leave it
   task automatic t_pd(input logic [3:0] c, input logic [2:0] st, input int exp_mode, input string tag);
      do_reset();
      step(1'b0, c, st);
      check({tag, " mode on entry"}, pwr_mode, exp_mode);
      check("R12 enter pulse", enter_pulse, 1);
      step(1'b0, C_DES, st);
      check("R12 enter pulse one cycle", enter_pulse, 0);
      step(1'b0, C_RD, 3'd1);
      step(1'b0, C_REF, 3'd0);
      check("R6 low-low keeps mode", pwr_mode, exp_mode);
      check("R6 no error", err_flag, 0);
      step(1'b1, C_NOP, 3'd0);
      check("R7 exit to normal", pwr_mode, 0);
      check("R7 exit pulse", exit_pulse, 1);
      step(1'b1, C_DES, 3'd0);
      check("R12 exit pulse one cycle", exit_pulse, 0);
      check("R10 legal hold no error", err_flag, 0);
   endtask

   task automatic t_decode();
      do_reset();
      step(1'b0, C_DESR, 3'd0);
      check("R2 cs_n high is deselect", pwr_mode, 2);
      check("R2 no error", err_flag, 0);
   endtask

   task automatic t_illegal();
      do_reset();
      step(1'b0, C_ACT, 3'd1);
      check("R9 other cmd err", err_flag, 1);
      check("R9 other cmd mode", pwr_mode, 0);
      check("R9 no enter", enter_pulse, 0);
      do_reset();
      step(1'b0, C_REF, 3'd1);
      check("R9 busy refresh err", err_flag, 1);
      check("R9 busy refresh mode", pwr_mode, 0);
      do_reset();
      step(1'b0, C_NOP, 3'd6);
      check("R9 bad state err", err_flag, 1);
      check("R9 bad state mode", pwr_mode, 0);
      do_reset();
      step(1'b0, C_NOP, 3'd1);
      step(1'b0, C_DES, 3'd1);
      step(1'b0, C_DES, 3'd1);
      step(1'b0, C_DES, 3'd1);
      check("R9 pre-check no error", err_flag, 0);
      step(1'b1, C_RD, 3'd1);
      check("R9 exit with other cmd err", err_flag, 1);
      check("R9 exit with other cmd mode", pwr_mode, 1);
      check("R9 no exit pulse", exit_pulse, 0);
      for (int i = 0; i < 4; i++) step(1'b1, C_NOP, 3'd0);
      check("R11 error stays set", err_flag, 1);
      do_reset();
      check("R11 reset clears error", err_flag, 0);
   endtask

   task automatic t_hold();
      do_reset();
      step(1'b0, C_NOP, 3'd0);
      step(1'b0, C_DES, 3'd0);
      step(1'b0, C_DES, 3'd0);
      step(1'b1, C_NOP, 3'd0);
      check("R10 change at hold boundary ok", err_flag, 0);
      check("R10 boundary exit mode", pwr_mode, 0);
      step(1'b1, C_DES, 3'd0);
      step(1'b0, C_NOP, 3'd0);
      check("R10 early change err", err_flag, 1);
      check("R10 mode still updated", pwr_mode, 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_normal();
      t_pd(C_NOP, 3'd1, 1, "R3 bank");
      t_pd(C_DES, 3'd2, 1, "R3 read");
      t_pd(C_NOP, 3'd3, 1, "R3 write");
      t_pd(C_DES, 3'd0, 2, "R4 idle");
      t_pd(C_NOP, 3'd4, 2, "R4 precharge");
      t_pd(C_DES, 3'd5, 2, "R4 refreshing");
      t_pd(C_REF, 3'd0, 3, "R5 self refresh");
      t_decode();
      t_illegal();
      t_hold();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule